// File: doc/BRIEF.md
# Error notification collector

This block is a bus target that receives error records for failed split transactions. Failures are not reported to the requester cycle by cycle; they are sent as messages to this collector. A message can come from the interconnect or from a target, and the causes include a timeout, a target that is busy or unavailable, and an identifier that names no target. Each message names the source whose request failed. Its tag names the collector it is meant for, so a system can route the errors of different groups of sources to different collectors. The collector keeps the records in a small queue in arrival order. A processor reads them through a two-word read port to find out which source issued the bad request.

A watchdog runs next to the queue. It keeps one timer for each source identifier and arms the timer when that source issues a read. If no response comes back in time, the watchdog turns the read into an error record of its own. It also returns a dummy response to the source in the same cycle, so the requester never waits forever. Every timer slot is a small state machine with three states: SLOT_IDLE, SLOT_WAIT and SLOT_EXPIRED. It moves along five transitions:
- **arm** (SLOT_IDLE to SLOT_WAIT), on a read from that source.
- **answer** (SLOT_WAIT to SLOT_IDLE), on a response to that source.
- **tick** (SLOT_WAIT to SLOT_WAIT), with the counter stepping by one.
- **expire** (SLOT_WAIT to SLOT_EXPIRED), when the counter reaches its limit.
- **take** (SLOT_EXPIRED to SLOT_IDLE), when the queue intake accepts the slot's record.

Top module: `err_collector`

## Requirements
- R1: After reset the queue is empty and the overflow flag is clear. Both read words return zero and `dmy_valid` is low.
- R2: An incoming error message is accepted only when `ev_valid` is high and `ev_tag` equals the COLLECTOR_ID parameter (default 5). Messages with any other tag leave the queue and the status word unchanged.
- R3: The failing source identifier is the top SRC_W bits of `ev_data`.
  - With `ev_we` high, the record is of kind 1 and keeps `ev_addr`.
  - With `ev_we` low, the record is of kind 0 and its address is zero.
  - The head word (offset 0) has bit 31 set when the queue is non-empty, the kind in bits 29:28, the source in bits 19:16 and the address in bits 15:0.
- R4: Records leave the queue in arrival order. A read strobe (`cpu_rd`) at offset 0 (`cpu_sel`=0) removes the head record at the clock edge. A read at offset 0 while the queue is empty returns zero and changes nothing.
- R5: The status word (offset 1) carries the overflow flag in bit 31 and the record count (0 to 8) in bits 3:0. All other bits are zero.
- R6: A record that arrives while 8 records are held is dropped, even if a removal happens in the same cycle. The overflow flag is then set, and the records already held are kept unchanged.
- R7: A read strobe at offset 1 clears the overflow flag. If a record is dropped in the same cycle, the flag stays set.
- R8: A read issued by source s (`rq_valid`, `rq_src`=s) arms slot s at that edge.
  - A response to s (`rs_valid`, `rs_src`=s) that is sampled within the next 64 edges disarms the slot and no record is made.
  - Without such a response, the slot expires at the 64th edge.
- R9: An expired slot's record is of kind 2 and carries the slot's source and the address of the timed-out read. In the cycle its record is accepted, `dmy_valid` is high, `dmy_src` names the source and `dmy_data` is all ones.
- R10: At most one record enters the queue per cycle.
  - An accepted incoming message takes precedence over expired slots.
  - Among expired slots, the lowest source number goes first.
  - An expired slot keeps its record until the record is accepted.
- R11: Each source has at most one armed read. A second read from a waiting or expired source is ignored and does not restart the timer. A response to an idle or expired source is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Incoming error message present |
| ev_tag | input | TAG_W | Collector identifier the message is addressed to |
| ev_data | input | DATA_W | Message data; failing source in the top SRC_W bits |
| ev_addr | input | ADDR_W | Target address of the failed request |
| ev_we | input | 1 | High when the message is request-side and carries the address |
| rq_valid | input | 1 | A read request is issued |
| rq_src | input | SRC_W | Source issuing the read |
| rq_addr | input | ADDR_W | Address of that read |
| rs_valid | input | 1 | A read response is returned |
| rs_src | input | SRC_W | Source receiving the response |
| cpu_rd | input | 1 | Read strobe of the processor port |
| cpu_sel | input | 1 | Word select: 0 head record, 1 status |
| cpu_rdata | output | DATA_W | Selected word (combinational) |
| dmy_valid | output | 1 | Dummy read response issued for a timed-out read |
| dmy_src | output | SRC_W | Source the dummy response goes to |
| dmy_data | output | DATA_W | Dummy response data, all ones |

## Verification
The assertions check these properties on every cycle:
- the count never exceeds the depth;
- a write into a full queue sets the flag and leaves the count at eight;
- a status read with no drop in the same cycle clears the flag;
- an intake into a non-full queue raises the count by one;
- a removal from an empty queue does nothing;
- at most one slot is granted per cycle, and none while an incoming message is accepted.

Only the bench scenarios can show the following:
- the bit layout of the head record;
- that the oldest records survive an overflow;
- the exact edge on which a timer expires, next to a response sampled on the last allowed edge;
- that a repeated read leaves the timer running;
- the lowest-first order of two records that are held back behind incoming messages.

// File: rtl/err_pkg.sv
package err_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_WAIT    = 2'd1,
        SLOT_EXPIRED = 2'd2
    } slot_state_t;

    typedef enum logic [1:0] {
        KIND_RESP = 2'd0,
        KIND_REQ  = 2'd1,
        KIND_TMO  = 2'd2
    } err_kind_t;

endpackage

// File: rtl/err_fifo.sv
module err_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // a full queue refuses the write even when a read frees a place
    assign do_push = push && (cnt != CW'(DEPTH));
    assign do_pop  = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign count = cnt;

endmodule

// File: rtl/err_watch_slot.sv
module err_watch_slot
    import err_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TMO_CYCLES = 64,
    localparam int CW        = $clog2(TMO_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              answer,
    input  logic              take,
    output logic              expired,
    output logic [ADDR_W-1:0] addr_o
);

    slot_state_t       state, nxt;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              at_limit;

    assign at_limit = (cnt == CW'(TMO_CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions: arm, answer, tick, expire, take
    always_comb begin
        nxt = state;
        unique case (state)
            SLOT_IDLE:    if (start) nxt = SLOT_WAIT;
            SLOT_WAIT: begin
                if (answer)        nxt = SLOT_IDLE;
                else if (at_limit) nxt = SLOT_EXPIRED;
            end
            SLOT_EXPIRED: if (take) nxt = SLOT_IDLE;
            default:      nxt = SLOT_IDLE;
        endcase
    end

    // timer and captured address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            addr_q <= '0;
        end else if (state == SLOT_IDLE && start) begin
            cnt    <= '0;
            addr_q <= start_addr;
        end else if (state == SLOT_WAIT && !at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        expired = (state == SLOT_EXPIRED);
        addr_o  = addr_q;
    end

endmodule

// File: rtl/err_pick.sv
module err_pick #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          fire,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        fire  = en && (|req);
        grant = fire ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/err_collector.sv
module err_collector
    import err_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                ADDR_W       = 16,
    parameter int                SRC_W        = 4,
    parameter int                TAG_W        = 4,
    parameter logic [TAG_W-1:0]  COLLECTOR_ID = 4'd5,
    parameter int                DEPTH        = 8,
    parameter int                TMO_CYCLES   = 64,
    localparam int               N_SRC        = 1 << SRC_W,
    localparam int               CNT_W        = $clog2(DEPTH + 1),
    localparam int               REC_W        = 2 + SRC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [TAG_W-1:0]  ev_tag,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_we,
    input  logic              rq_valid,
    input  logic [SRC_W-1:0]  rq_src,
    input  logic [ADDR_W-1:0] rq_addr,
    input  logic              rs_valid,
    input  logic [SRC_W-1:0]  rs_src,
    input  logic              cpu_rd,
    input  logic              cpu_sel,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dmy_valid,
    output logic [SRC_W-1:0]  dmy_src,
    output logic [DATA_W-1:0] dmy_data
);

    logic              ext_acc;
    logic [N_SRC-1:0]  expired, grant;
    logic [ADDR_W-1:0] slot_addr [N_SRC];
    logic              wd_fire;
    logic [SRC_W-1:0]  wd_idx;
    logic              push_req, pop_req, drop;
    logic [REC_W-1:0]  rec_in, rec_head;
    logic [CNT_W-1:0]  fifo_count;
    logic              ovf_q;
    err_kind_t         ext_kind;

    assign ext_acc  = ev_valid && (ev_tag == COLLECTOR_ID);
    assign ext_kind = ev_we ? KIND_REQ : KIND_RESP;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_slot
            err_watch_slot #(
                .ADDR_W    (ADDR_W),
                .TMO_CYCLES(TMO_CYCLES)
            ) slot_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .start     (rq_valid && (rq_src == SRC_W'(s))),
                .start_addr(rq_addr),
                .answer    (rs_valid && (rs_src == SRC_W'(s))),
                .take      (grant[s]),
                .expired   (expired[s]),
                .addr_o    (slot_addr[s])
            );
        end
    endgenerate

    err_pick #(.N(N_SRC)) pick_i (
        .en   (!ext_acc),
        .req  (expired),
        .grant(grant),
        .fire (wd_fire),
        .idx  (wd_idx)
    );

    always_comb begin
        if (ext_acc) begin
            rec_in = {ext_kind, ev_data[DATA_W-1 -: SRC_W], ev_we ? ev_addr : ADDR_W'(0)};
        end else begin
            rec_in = {KIND_TMO, wd_idx, slot_addr[wd_idx]};
        end
    end

    assign push_req = ext_acc || wd_fire;
    assign pop_req  = cpu_rd && !cpu_sel;
    assign drop     = push_req && (fifo_count == CNT_W'(DEPTH));

    err_fifo #(.W(REC_W), .DEPTH(DEPTH)) fifo_i (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push_req),
        .pop  (pop_req),
        .din  (rec_in),
        .dout (rec_head),
        .count(fifo_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (drop) begin
            ovf_q <= 1'b1;
        end else if (cpu_rd && cpu_sel) begin
            ovf_q <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel) begin
            cpu_rdata[DATA_W-1]  = ovf_q;
            cpu_rdata[CNT_W-1:0] = fifo_count;
        end else if (fifo_count != '0) begin
            cpu_rdata[DATA_W-1]         = 1'b1;
            cpu_rdata[DATA_W-3 -: 2]    = rec_head[REC_W-1 -: 2];
            cpu_rdata[ADDR_W +: SRC_W]  = rec_head[ADDR_W +: SRC_W];
            cpu_rdata[ADDR_W-1:0]       = rec_head[ADDR_W-1:0];
        end
    end

    assign dmy_valid = wd_fire;
    assign dmy_src   = wd_idx;
    assign dmy_data  = '1;

endmodule

// File: rtl/err_collector_chk.sv
module err_collector_chk #(
    parameter int DEPTH = 8,
    parameter int N_SRC = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             push_req,
    input logic             ext_acc,
    input logic             cpu_rd,
    input logic             cpu_sel,
    input logic             ovf,
    input logic             drop,
    input logic [N_SRC-1:0] grant
);

    logic pop_req;
    assign pop_req = cpu_rd && !cpu_sel;

    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (count == '0) && !ovf);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && (count == CNT_W'(DEPTH)) && !pop_req) |=> ovf && (count == CNT_W'(DEPTH)));

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel && !drop) |=> !ovf);

    assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && (count < CNT_W'(DEPTH))) |=> count == $past(count) + 1'b1);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (count == '0) && !push_req) |=> count == '0);

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_ext_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_acc |-> (grant == '0));

endmodule

bind err_collector err_collector_chk #(
    .DEPTH(DEPTH),
    .N_SRC(N_SRC),
    .CNT_W(CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (fifo_count),
    .push_req(push_req),
    .ext_acc (ext_acc),
    .cpu_rd  (cpu_rd),
    .cpu_sel (cpu_sel),
    .ovf     (ovf_q),
    .drop    (drop),
    .grant   (grant)
);

// File: tb/err_collector_tb_top.sv
`timescale 1ns/1ps
module err_collector_tb_top;

    localparam logic [3:0] ID = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 0, ev_we = 0, rq_valid = 0, rs_valid = 0, cpu_rd = 0, cpu_sel = 0;
    logic [3:0]  ev_tag = 0, rq_src = 0, rs_src = 0;
    logic [31:0] ev_data = 0;
    logic [15:0] ev_addr = 0, rq_addr = 0;
    logic [31:0] cpu_rdata, dmy_data;
    logic        dmy_valid;
    logic [3:0]  dmy_src;

    always #2 clk = ~clk;

    err_collector dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_data(ev_data), .ev_addr(ev_addr), .ev_we(ev_we),
        .rq_valid(rq_valid), .rq_src(rq_src), .rq_addr(rq_addr),
        .rs_valid(rs_valid), .rs_src(rs_src),
        .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_rdata(cpu_rdata),
        .dmy_valid(dmy_valid), .dmy_src(dmy_src), .dmy_data(dmy_data)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq[$];
    bit          movf;
    int          mst [16];
    int          mcnt[16];
    logic [15:0] maddr[16];

    function automatic logic [31:0] mk(int kind, int src, logic [15:0] addr);
        logic [31:0] w;
        w = 32'h8000_0000;
        w[29:28] = 2'(kind);
        w[19:16] = 4'(src);
        w[15:0]  = addr;
        return w;
    endfunction

    function automatic int lowest_expired();
        for (int i = 0; i < 16; i++) if (mst[i] == 2) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            movf = 0;
            for (int i = 0; i < 16; i++) begin mst[i] = 0; mcnt[i] = 0; maddr[i] = 0; end
        end else begin
            bit ext, push, drop, pop;
            int g;
            logic [31:0] w;
            ext = ev_valid && (ev_tag == ID);
            g = ext ? -1 : lowest_expired();
            push = ext || (g >= 0);
            w = 0;
            if (ext) w = mk(ev_we ? 1 : 0, int'(ev_data[31:28]), ev_we ? ev_addr : 16'h0);
            else if (g >= 0) w = mk(2, g, maddr[g]);
            pop = cpu_rd && !cpu_sel && (mq.size() > 0);
            drop = push && (mq.size() == 8);
            if (drop) movf = 1;
            else if (cpu_rd && cpu_sel) movf = 0;
            if (pop) void'(mq.pop_front());
            if (push && !drop) mq.push_back(w);
            for (int i = 0; i < 16; i++) begin
                if (i == g) mst[i] = 0;
                else if (mst[i] == 0) begin
                    if (rq_valid && rq_src == 4'(i)) begin mst[i] = 1; mcnt[i] = 0; maddr[i] = rq_addr; end
                end else if (mst[i] == 1) begin
                    if (rs_valid && rs_src == 4'(i)) mst[i] = 0;
                    else if (mcnt[i] == 63) mst[i] = 2;
                    else mcnt[i]++;
                end
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [31:0] er;
        int g;
        bit ext;
        if (cpu_sel) er = {movf, 27'b0, 4'(mq.size())};
        else er = (mq.size() > 0) ? mq[0] : 32'h0;
        check(cpu_rdata === er, cpu_sel ? "R5 status word" : "R3 head word", cpu_rdata, er);
        ext = ev_valid && (ev_tag == ID);
        g = ext ? -1 : lowest_expired();
        check(dmy_valid === (g >= 0), "R9 dummy valid", {31'b0, dmy_valid}, {31'b0, g >= 0});
        if (g >= 0) begin
            check(dmy_src === 4'(g), "R10 dummy source", {28'b0, dmy_src}, 32'(g));
            check(dmy_data === 32'hFFFF_FFFF, "R9 dummy data", dmy_data, 32'hFFFF_FFFF);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        if (rst_n) compare_model();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_ev(logic [3:0] tag, logic [3:0] src, logic we, logic [15:0] addr);
        ev_valid = 1; ev_tag = tag; ev_data = {src, 28'h0ABCDEF}; ev_we = we; ev_addr = addr;
        tick();
        ev_valid = 0; ev_we = 0;
    endtask

    task automatic read_req(logic [3:0] src, logic [15:0] addr);
        rq_valid = 1; rq_src = src; rq_addr = addr;
        tick();
        rq_valid = 0;
    endtask

    task automatic respond(logic [3:0] src);
        rs_valid = 1; rs_src = src;
        tick();
        rs_valid = 0;
    endtask

    task automatic peek(logic sel, logic [31:0] exp, string req);
        cpu_rd = 0; cpu_sel = sel;
        #0.5;
        check(cpu_rdata === exp, req, cpu_rdata, exp);
    endtask

    task automatic pop_one(logic [31:0] exp, string req);
        cpu_sel = 0;
        #0.5;
        check(cpu_rdata === exp, req, cpu_rdata, exp);
        cpu_rd = 1;
        tick();
        cpu_rd = 0;
    endtask

    task automatic read_status();
        cpu_sel = 1; cpu_rd = 1;
        tick();
        cpu_rd = 0; cpu_sel = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired, run hung");
        summary();
    end

    initial begin
        ticks(3);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        peek(0, 32'h0, "R1 head after reset");
        peek(1, 32'h0, "R1 status after reset");
        check(dmy_valid === 1'b0, "R1 no dummy after reset", {31'b0, dmy_valid}, 0);

        // R2, R3: intake and record format
        send_ev(ID, 4'hA, 0, 16'hBEEF);
        send_ev(ID, 4'h3, 1, 16'h1234);
        send_ev(4'd6, 4'h7, 1, 16'h7777);
        peek(1, 32'h0000_0002, "R2 wrong tag ignored");
        pop_one(32'h800A_0000, "R3 response-form record");
        pop_one(32'h9003_1234, "R3 request-form record");
        // R4: empty pop
        pop_one(32'h0, "R4 empty head reads zero");
        peek(1, 32'h0, "R4 empty pop no effect");

        // R6: overflow
        for (int i = 0; i < 10; i++) send_ev(ID, 4'(i), 0, 16'h0);
        peek(1, 32'h8000_0008, "R6 overflow status");
        pop_one(32'h8000_0000, "R6 oldest kept");
        read_status();
        peek(1, 32'h0000_0007, "R7 status read clears");
        for (int i = 1; i < 8; i++) pop_one(mk(0, i, 16'h0), "R6 newest dropped");
        peek(1, 32'h0, "R5 drained");

        // R7: drop in the same cycle as a status read
        for (int i = 0; i < 8; i++) send_ev(ID, 4'hE, 1, 16'(i));
        ev_valid = 1; ev_tag = ID; ev_data = 32'hF000_0000; ev_we = 0;
        cpu_sel = 1; cpu_rd = 1;
        tick();
        ev_valid = 0; cpu_rd = 0;
        peek(1, 32'h8000_0008, "R7 drop beats clear");
        read_status();
        for (int i = 0; i < 8; i++) pop_one(mk(1, 14, 16'(i)), "R4 fifo order");
        peek(1, 32'h0, "R7 cleared and empty");

        // R8: response on the last allowed edge cancels
        read_req(4'd3, 16'h1111);
        ticks(63);
        respond(4'd3);
        ticks(5);
        peek(1, 32'h0, "R8 answered read leaves no record");

        // R8, R9: expiry
        read_req(4'd2, 16'h2222);
        ticks(63);
        check(dmy_valid === 1'b0, "R8 not expired at edge 63", {31'b0, dmy_valid}, 0);
        tick();
        check(dmy_valid === 1'b1, "R8 expired at edge 64", {31'b0, dmy_valid}, 1);
        check(dmy_src === 4'd2, "R9 dummy source", {28'b0, dmy_src}, 2);
        tick();
        pop_one(32'hA002_2222, "R9 timeout record");

        // R11: repeat request ignored
        read_req(4'd5, 16'h5555);
        ticks(30);
        read_req(4'd5, 16'h9999);
        respond(4'd9);
        ticks(32);
        check(dmy_valid === 1'b1 && dmy_src === 4'd5, "R11 timer not restarted",
              {27'b0, dmy_valid, dmy_src}, {27'b0, 1'b1, 4'd5});
        tick();
        pop_one(32'hA005_5555, "R11 first address kept");

        // R10: held records and lowest-first order
        read_req(4'd6, 16'h6666);
        read_req(4'd1, 16'h0101);
        ticks(62);
        ev_valid = 1; ev_tag = ID; ev_data = 32'hC000_0000; ev_we = 0;
        tick();
        check(dmy_valid === 1'b0, "R10 message beats expired slot", {31'b0, dmy_valid}, 0);
        tick();
        ev_valid = 0;
        #0.5;
        check(dmy_valid === 1'b1 && dmy_src === 4'd1, "R10 lowest first",
              {27'b0, dmy_valid, dmy_src}, {27'b0, 1'b1, 4'd1});
        tick();
        check(dmy_valid === 1'b1 && dmy_src === 4'd6, "R10 next slot",
              {27'b0, dmy_valid, dmy_src}, {27'b0, 1'b1, 4'd6});
        tick();
        peek(1, 32'h0000_0004, "R10 four records");
        pop_one(32'h800C_0000, "R10 message one");
        pop_one(32'h800C_0000, "R10 message two");
        pop_one(32'hA001_0101, "R10 slot one");
        pop_one(32'hA006_6666, "R10 slot six");
        ticks(3);
        summary();
    end

endmodule